// File: doc/BRIEF.md
# ROM XOR Checksum Verifier

A self-test engine that checks the integrity of a byte-wide read-only memory after power-up. It reads every byte of the memory once, in rising address order, over a synchronous read port with a fixed read latency. It pairs the bytes into 16-bit words, with the even-address byte in the upper half. All words except the final one are folded into a running 16-bit XOR signature. The final word of the image is the reference checksum. The signature is compared with that reference and the outcome is reported on a pass flag that stays valid until the next run.

The engine starts by itself on the first clock edge after reset is released. A host can request further runs with a one-cycle start pulse while the engine is idle. A start pulse that arrives during a run is dropped. Both 16-bit values are visible on output ports, so a failing image can be inspected.

Control is a four-state machine:
- **IDLE** moves to **READ** when a run is accepted. A run is accepted when the post-reset launch is still pending or `start_i` is high.
- **READ** issues one read per cycle. It moves to **DRAIN** on the cycle that issues the read of the highest address.
- **DRAIN** waits for the data of that last read and then moves to **DONE**.
- **DONE** lasts one cycle, publishes the verdict, and returns to **IDLE**.

Top module: `rom_sig_check`

## Requirements
- R1: After reset is released, a run starts on the first clock edge without any start pulse, and `busy_o` is high in the cycle after that edge.
- R2: A run asserts `rd_en_o` for exactly MEM_BYTES consecutive cycles, presenting addresses 0, 1, ..., MEM_BYTES-1 in that order, the first one being address 0.
- R3: At the end of a run, `calc_sum_o` equals the XOR of the words {byte[2k], byte[2k+1]} (even byte in bits 15:8) for k = 0 .. MEM_BYTES/2-2, that is, every byte except the last two; the value is 0x0000 when there are no such words.
- R4: At the end of a run, `ref_sum_o` equals {byte[MEM_BYTES-2], byte[MEM_BYTES-1]}, with the byte at the lower address in bits 15:8.
- R5: In the cycle where `done_o` is high, `pass_o` is 1 exactly when `calc_sum_o` equals `ref_sum_o`, and 0 otherwise. After that cycle, `pass_o` holds that value until the next run is accepted.
- R6: If a run is accepted on clock edge 0, `busy_o` is high for the MEM_BYTES+RD_LAT cycles that follow edges 0 through MEM_BYTES+RD_LAT-1. `done_o` is then high for a single cycle, after edge MEM_BYTES+RD_LAT, and `busy_o` is low in that cycle.
- R7: `start_i` is ignored while `busy_o` is high. Such a pulse does not change the read sequence, the timing of `done_o`, or the result, and it does not produce a second run.
- R8: Accepting a run clears the signature and the verdict. `pass_o` is 0 while `busy_o` is high, and the result of a run does not depend on the runs before it.
- R9: A one-cycle `start_i` pulse while idle starts a new run, and `busy_o` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new run when idle |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Byte address of the read |
| rd_data_i | input | 8 | Read data, valid RD_LAT cycles after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Signature matched the stored checksum |
| calc_sum_o | output | 16 | Computed XOR signature |
| ref_sum_o | output | 16 | Checksum read from the final two bytes |

## Verification
The bench builds the engine with MEM_BYTES = 40 and RD_LAT = 3.

A size that is not a power of two means the end-of-scan decision cannot rely on the address counter wrapping. It also gives an odd number (19) of folded words, so an all-0xFF image folds to 0xFFFF and passes.

A latency of three keeps several reads in flight at once. This exposes any error in tagging returned bytes as even, odd or reference. It also separates the DRAIN wait from the READ phase by more than one cycle, which makes a start pulse landing in the drain window a distinct case.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } rsc_state_e;

    // Per-read tag carried alongside the memory latency.
    typedef struct packed {
        logic vld;     // a byte returns this cycle
        logic odd;     // byte sits at an odd address (low half of a word)
        logic is_ref;  // byte belongs to the stored checksum
        logic last;    // final byte of the image
    } rsc_tag_t;

endpackage

// File: rtl/rsc_read_seq.sv
module rsc_read_seq
    import rsc_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int RD_LAT    = 2,
    localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              issue_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              last_issue_o,
    output rsc_tag_t          tag_o
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MEM_BYTES - 1);
    localparam logic [ADDR_W-1:0] REF_A  = ADDR_W'(MEM_BYTES - 2);

    logic [ADDR_W-1:0] cnt_q;
    rsc_tag_t          head;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (issue_i) begin
            cnt_q <= cnt_q + ADDR_W'(1);
        end
    end

    assign rd_en_o      = issue_i;
    assign rd_addr_o    = cnt_q;
    assign last_issue_o = issue_i && (cnt_q == LAST_A);

    always_comb begin
        head = '0;
        if (issue_i) begin
            head.vld    = 1'b1;
            head.odd    = cnt_q[0];
            head.is_ref = (cnt_q >= REF_A);
            head.last   = (cnt_q == LAST_A);
        end
    end

    // Tag delay line matching the memory read latency.
    generate
        if (RD_LAT == 1) begin : g_lat_one
            rsc_tag_t pipe_q;
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= head;
            end
            assign tag_o = pipe_q;
        end else begin : g_lat_multi
            rsc_tag_t pipe_q [RD_LAT];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < RD_LAT; i++) pipe_q[i] <= '0;
                end else begin
                    pipe_q[0] <= head;
                    for (int i = 1; i < RD_LAT; i++) pipe_q[i] <= pipe_q[i-1];
                end
            end
            assign tag_o = pipe_q[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/rsc_fold.sv
module rsc_fold
    import rsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  rsc_tag_t    tag_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] calc_o,
    output logic [15:0] ref_o
);

    logic [7:0]  hi_q;
    logic [15:0] acc_q;
    logic [15:0] ref_q;
    logic [15:0] word;

    assign word = {hi_q, byte_i};

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hi_q  <= '0;
            acc_q <= '0;
            ref_q <= '0;
        end else if (tag_i.vld) begin
            if (!tag_i.odd) begin
                hi_q <= byte_i;
            end else if (tag_i.is_ref) begin
                ref_q <= word;
            end else begin
                acc_q <= acc_q ^ word;
            end
        end
    end

    assign calc_o = acc_q;
    assign ref_o  = ref_q;

endmodule

// File: rtl/rom_sig_check.sv
module rom_sig_check
    import rsc_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int RD_LAT    = 2,
    localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [15:0]       calc_sum_o,
    output logic [15:0]       ref_sum_o
);

    rsc_state_e state_q, state_d;
    logic       boot_q;
    logic       pass_q;
    logic       accept;
    logic       issue;
    logic       last_issue;
    logic       match;
    rsc_tag_t   tag;

    assign accept = (state_q == ST_IDLE) && (boot_q || start_i);
    assign match  = (calc_sum_o == ref_sum_o);

    rsc_read_seq #(
        .MEM_BYTES (MEM_BYTES),
        .RD_LAT    (RD_LAT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (accept),
        .issue_i      (issue),
        .rd_en_o      (rd_en_o),
        .rd_addr_o    (rd_addr_o),
        .last_issue_o (last_issue),
        .tag_o        (tag)
    );

    rsc_fold u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .tag_i  (tag),
        .byte_i (rd_data_i),
        .calc_o (calc_sum_o),
        .ref_o  (ref_sum_o)
    );

    // State register and run bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            boot_q  <= 1'b1;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                boot_q <= 1'b0;
                pass_q <= 1'b0;
            end else if (state_q == ST_DONE) begin
                pass_q <= match;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)                 state_d = ST_READ;
            ST_READ:  if (last_issue)             state_d = ST_DRAIN;
            ST_DRAIN: if (tag.vld && tag.last)    state_d = ST_DONE;
            ST_DONE:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        issue  = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        pass_o = pass_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  begin issue = 1'b1; busy_o = 1'b1; end
            ST_DRAIN: busy_o = 1'b1;
            ST_DONE:  begin done_o = 1'b1; pass_o = match; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/rsc_check.sv
module rsc_check #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o
);

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_o) |-> rd_addr_o == '0);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));

    assert_read_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    assert_verdict_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy_o) && !busy_o) |-> $stable(pass_o));

    assert_start_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    assert_pass_low_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !pass_o);

endmodule

bind rom_sig_check rsc_check #(.ADDR_W(ADDR_W)) u_rsc_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o)
);

// File: tb/rom_sig_check_bench.sv
`timescale 1ns/1ps
module rom_sig_check_bench;

    localparam int N   = 40;
    localparam int LAT = 3;
    localparam int AW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          busy, done, pass;
    logic [15:0]   calc, refv;

    logic [7:0] mem [N];
    logic [7:0] mpipe [LAT];

    int n_tests = 0;
    int n_fail  = 0;
    int n_rd, exp_addr, rd_bad;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rom_sig_check #(.MEM_BYTES(N), .RD_LAT(LAT)) u_rom_sig_check (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .pass_o(pass),
        .calc_sum_o(calc), .ref_sum_o(refv)
    );

    // Memory model: data for a read taken at edge e is on the bus after edge e+LAT-1.
    always @(posedge clk) begin
        mpipe[0] <= rd_en ? mem[rd_addr] : 8'h00;
        for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
    end
    assign rd_data = mpipe[LAT-1];

    // Read monitor.
    always @(negedge clk) begin
        if (rd_en) begin
            if (rd_addr !== exp_addr[AW-1:0]) rd_bad++;
            exp_addr++;
            n_rd++;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_calc();
        logic [15:0] s = 16'h0000;
        for (int k = 0; k < N/2 - 1; k++) s ^= {mem[2*k], mem[2*k+1]};
        return s;
    endfunction

    function automatic logic [15:0] f_ref();
        return {mem[N-2], mem[N-1]};
    endfunction

    task automatic seal();
        logic [15:0] s = f_calc();
        mem[N-2] = s[15:8];
        mem[N-1] = s[7:0];
    endtask

    task automatic fill_random(input bit good);
        for (int i = 0; i < N; i++) mem[i] = 8'($urandom);
        seal();
        if (!good) mem[N-1 - ($urandom % 2)] ^= 8'(1 << ($urandom % 8));
    endtask

    task automatic fill_const(input logic [7:0] v, input bit do_seal);
        for (int i = 0; i < N; i++) mem[i] = v;
        if (do_seal) seal();
    endtask

    // Runs one test; called at a negedge while idle (or right after reset release).
    task automatic run(input bit use_start, input bit spam, input string lbl);
        int c = 0;
        int gap = 0;
        int leak = 0;
        int extra = 0;
        logic exp_pass;
        n_rd = 0; exp_addr = 0; rd_bad = 0;
        exp_pass = (f_calc() == f_ref());
        if (use_start) start = 1'b1;
        forever begin
            @(negedge clk);
            c++;
            start = spam && (c >= 2) && (c < N + LAT) && (c % 3 == 0);
            if (c == 1) check(use_start ? "R9" : "R1", {lbl, " busy after accept"}, busy, 1);
            if (c > 1 && c <= N + LAT && !busy) gap++;
            if (busy && pass) leak++;
            if (done) break;
            if (c > N + LAT + 5) begin
                check("R6", {lbl, " done never seen"}, 0, 1);
                break;
            end
        end
        start = 1'b0;
        check("R6", {lbl, " done cycle"}, c, N + LAT + 1);
        check("R6", {lbl, " busy continuous"}, gap, 0);
        check("R6", {lbl, " busy low at done"}, busy, 0);
        check("R2", {lbl, " read count"}, n_rd, N);
        check("R2", {lbl, " address order"}, rd_bad, 0);
        check("R3", {lbl, " signature"}, calc, f_calc());
        check("R4", {lbl, " stored checksum"}, refv, f_ref());
        check("R5", {lbl, " verdict at done"}, pass, exp_pass);
        check("R8", {lbl, " pass low while busy"}, leak, 0);
        for (int i = 0; i < N + LAT + 4; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check(spam ? "R7" : "R6", {lbl, " no second run"}, extra, 0);
        check("R5", {lbl, " verdict held"}, pass, exp_pass);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0D));
        fill_random(1'b1);
        repeat (5) @(negedge clk);
        check("R1", "reset busy", busy, 0);
        check("R6", "reset done", done, 0);
        check("R2", "reset rd_en", rd_en, 0);
        check("R5", "reset pass", pass, 0);
        rst_n = 1'b1;
        run(1'b0, 1'b0, "boot");

        // Directed corners.
        fill_const(8'h00, 1'b0);  run(1'b1, 1'b0, "zeros");
        fill_const(8'hFF, 1'b0);  run(1'b1, 1'b0, "ones");
        fill_const(8'hFF, 1'b1);  run(1'b1, 1'b0, "ones_sealed");
        check("R3", "odd word count of 0xFFFF", calc, 16'hFFFF);
        fill_random(1'b0);        run(1'b1, 1'b0, "bitflip");
        check("R5", "corrupt image fails", pass, 0);
        fill_random(1'b1);        run(1'b1, 1'b1, "start_spam");
        check("R8", "pass after a failing run", pass, 1);

        // Constrained random runs.
        for (int t = 0; t < 8; t++) begin
            fill_random(t % 3 != 0);
            run(1'b1, t % 2 == 1, "rand");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule